// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. The segment descriptors sit in a table in memory. Two configuration registers hold the byte address where that table starts and the number of segments it holds. For each request the unit first checks that the segment number is in range. If it is, the unit reads the two-word descriptor of that segment over a simple memory read port. It then tests the offset against the segment's size and the access type against the segment's permission bits. The result is either the physical address or a fault code naming the first rule that was broken.

Only one translation is in flight at a time. A request is taken with a valid/ready handshake. The table location and the segment count are read at the moment the request is taken, so configuration writes made while a translation is running only affect later requests. The answer appears as a one-cycle result pulse. Descriptor word 0 holds the segment base. Descriptor word 1 holds the segment limit in bits 15:0 and permission bits in bits 18:16: bit 16 allows reads, bit 17 allows writes and bit 18 allows execution.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0 and mem_rd_req is 0. Both configuration registers are 0, so the first request after reset fails with fault code 1.
- R2: When cfg_we is 1 on a clock edge, cfg_sel = 0 loads the table base address from cfg_wdata and cfg_sel = 1 loads the segment count from cfg_wdata[16:0].
- R3: A request whose segment number is greater than or equal to the segment count ends with fault code 1. It makes no memory read, and res_valid rises in the cycle right after the request is accepted.
- R4: A legal request makes exactly two reads. The first is word 0 at address table_base + 8*segment and the second is word 1 at that address + 4, both modulo 2^32.
- R5: mem_rd_req stays high, with mem_rd_addr unchanged, until mem_rd_gnt is seen. Each granted read is completed by one mem_rd_rvalid in a later cycle, which carries mem_rd_data, and only one read is outstanding at a time.
- R6: If the offset is greater than or equal to the 16-bit limit in word 1 bits 15:0, the result is fault code 2.
- R7: The access code is 0 for read, 1 for write, 2 for execute and 3 for a code that no permission grants. An access whose permission bit (word 1 bit 16, 17 or 18 respectively) is clear gives fault code 3.
- R8: When several checks fail, fault 1 wins over fault 2, and fault 2 wins over fault 3.
- R9: When no check fails, res_fault is 0 and res_paddr = base + offset modulo 2^32. On any fault, res_paddr is 0.
- R10: req_ready is low from the acceptance edge until the result cycle has ended. res_valid lasts exactly one cycle, and req_ready is high again in the cycle after it.
- R11: A configuration write made after a request is accepted does not change that request's fetch addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table base address, 1 selects the segment count |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_seg | input | 16 | Segment number |
| req_off | input | 16 | Offset inside the segment |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 none |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Byte address of the descriptor word being read |
| mem_rd_gnt | input | 1 | Memory takes the read request |
| mem_rd_rvalid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 2 | Fault code: 0 none, 1 bad segment, 2 out of bounds, 3 protection |
| res_paddr | output | 32 | Physical address, 0 on fault |

## Verification
Corrupted captured state shows up at one of two places, depending on which state is wrong. A wrong descriptor address becomes visible at the first grant, where the memory model compares mem_rd_addr with the address it expects. A wrong captured offset, access code or descriptor word first shows in the single result cycle, as a wrong fault code or physical address. A broken sequencer shows up as a read count other than zero or two for that translation, as a result pulse that is late on an illegal segment, or as req_ready seen high while the unit is busy. Each of these is visible within the translation in which the fault happens. The random runs mix illegal segment numbers, offsets close to each limit, every access code and base values close to the address wrap.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_SEG   = 2'd1,
      FLT_BOUND = 2'd2,
      FLT_PROT  = 2'd3
   } seg_fault_e;

   typedef enum logic [1:0] {
      ACC_RD   = 2'd0,
      ACC_WR   = 2'd1,
      ACC_EX   = 2'd2,
      ACC_NONE = 2'd3
   } seg_acc_e;

   localparam int PERM_N  = 3;
   localparam int ACC_W   = 2;
   localparam int FAULT_W = 2;

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
   parameter int CFG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [ADDR_W-1:0] tbl_base,
   output logic [LEN_W-1:0]  tbl_len
);

   if (ADDR_W > CFG_W) begin : g_addr_w_err
      $error("seg_cfg_regs: ADDR_W wider than configuration data");
   end
   if (LEN_W > CFG_W) begin : g_len_w_err
      $error("seg_cfg_regs: LEN_W wider than configuration data");
   end

   // table base register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_base <= '0;
      end else if (cfg_we && !cfg_sel) begin
         tbl_base <= cfg_wdata[ADDR_W-1:0];
      end
   end

   // segment count register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_len <= '0;
      end else if (cfg_we && cfg_sel) begin
         tbl_len <= cfg_wdata[LEN_W-1:0];
      end
   end

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = SEG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [ACC_W-1:0]  req_acc,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [LEN_W-1:0]  tbl_len,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_gnt,
   input  logic              mem_rd_rvalid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              seg_bad,
   output logic [OFF_W-1:0]  cap_off,
   output logic [ACC_W-1:0]  cap_acc,
   output logic [DATA_W-1:0] ent_word0,
   output logic [DATA_W-1:0] ent_word1,
   output logic              res_valid
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int ENT_BYTES  = 2 * WORD_BYTES;
   localparam int ENT_SH     = $clog2(ENT_BYTES);

   if (DATA_W % 8 != 0) begin : g_data_w_err
      $error("seg_fetch_ctrl: DATA_W must be whole bytes");
   end
   if ((1 << ENT_SH) != ENT_BYTES) begin : g_ent_pow2_err
      $error("seg_fetch_ctrl: descriptor size must be a power of two");
   end
   if (SEG_W + ENT_SH > ADDR_W) begin : g_seg_w_err
      $error("seg_fetch_ctrl: segment index does not fit the address");
   end

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ0,
      ST_WAIT0,
      ST_REQ1,
      ST_WAIT1,
      ST_DONE
   } fetch_st_e;

   fetch_st_e         state;
   logic [ADDR_W-1:0] ent_addr;
   logic              seg_legal;
   logic [ADDR_W-1:0] first_addr;

   assign seg_legal  = LEN_W'(req_seg) < tbl_len;
   assign first_addr = tbl_base + (ADDR_W'(req_seg) << ENT_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ent_addr  <= '0;
         seg_bad   <= 1'b0;
         cap_off   <= '0;
         cap_acc   <= '0;
         ent_word0 <= '0;
         ent_word1 <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  cap_off  <= req_off;
                  cap_acc  <= req_acc;
                  ent_addr <= first_addr;
                  seg_bad  <= !seg_legal;
                  state    <= seg_legal ? ST_REQ0 : ST_DONE;
               end
            end
            ST_REQ0: begin
               if (mem_rd_gnt) state <= ST_WAIT0;
            end
            ST_WAIT0: begin
               if (mem_rd_rvalid) begin
                  ent_word0 <= mem_rd_data;
                  ent_addr  <= ent_addr + ADDR_W'(WORD_BYTES);
                  state     <= ST_REQ1;
               end
            end
            ST_REQ1: begin
               if (mem_rd_gnt) state <= ST_WAIT1;
            end
            ST_WAIT1: begin
               if (mem_rd_rvalid) begin
                  ent_word1 <= mem_rd_data;
                  state     <= ST_DONE;
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state == ST_IDLE);
   assign mem_rd_req  = (state == ST_REQ0) || (state == ST_REQ1);
   assign mem_rd_addr = ent_addr;
   assign res_valid   = (state == ST_DONE);

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_W    = 16,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int LIM_W    = 16,
   parameter int PERM_LSB = 16
) (
   input  logic                seg_bad,
   input  logic [OFF_W-1:0]    cap_off,
   input  logic [ACC_W-1:0]    cap_acc,
   input  logic [DATA_W-1:0]   ent_word0,
   input  logic [DATA_W-1:0]   ent_word1,
   output logic [FAULT_W-1:0]  res_fault,
   output logic [ADDR_W-1:0]   res_paddr
);

   if (LIM_W > PERM_LSB) begin : g_lim_overlap_err
      $error("seg_check: limit field overlaps permission bits");
   end
   if (PERM_LSB + PERM_N > DATA_W) begin : g_perm_w_err
      $error("seg_check: permission bits beyond descriptor word");
   end
   if (ADDR_W > DATA_W) begin : g_base_w_err
      $error("seg_check: base word narrower than address");
   end
   if (OFF_W > LIM_W) begin : g_off_w_err
      $error("seg_check: offset wider than limit field");
   end

   logic [LIM_W-1:0]  seg_lim;
   logic [PERM_N-1:0] seg_perm;
   logic [PERM_N-1:0] perm_hit;
   logic              in_bounds;
   logic              allowed;
   seg_fault_e        fault;

   assign seg_lim   = ent_word1[LIM_W-1:0];
   assign seg_perm  = ent_word1[PERM_LSB +: PERM_N];
   assign in_bounds = LIM_W'(cap_off) < seg_lim;

   for (genvar i = 0; i < PERM_N; i++) begin : g_perm
      assign perm_hit[i] = seg_perm[i] && (cap_acc == ACC_W'(i));
   end

   assign allowed = |perm_hit;

   always_comb begin
      if (seg_bad)         fault = FLT_SEG;
      else if (!in_bounds) fault = FLT_BOUND;
      else if (!allowed)   fault = FLT_PROT;
      else                 fault = FLT_NONE;
   end

   assign res_fault = fault;
   assign res_paddr = (fault == FLT_NONE) ?
                      ent_word0[ADDR_W-1:0] + ADDR_W'(cap_off) : '0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int SEG_W    = 16,
   parameter int OFF_W    = 16,
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int CFG_W    = 32,
   parameter int PERM_LSB = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [1:0]        req_acc,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_gnt,
   input  logic              mem_rd_rvalid,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              res_valid,
   output logic [1:0]        res_fault,
   output logic [ADDR_W-1:0] res_paddr
);

   localparam int LEN_W = SEG_W + 1;
   localparam int LIM_W = OFF_W;

   logic [ADDR_W-1:0] tbl_base;
   logic [LEN_W-1:0]  tbl_len;
   logic              seg_bad;
   logic [OFF_W-1:0]  cap_off;
   logic [ACC_W-1:0]  cap_acc;
   logic [DATA_W-1:0] ent_word0;
   logic [DATA_W-1:0] ent_word1;

   seg_cfg_regs #(
      .CFG_W (CFG_W),
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .tbl_base (tbl_base),
      .tbl_len  (tbl_len)
   );

   seg_fetch_ctrl #(
      .SEG_W (SEG_W),
      .OFF_W (OFF_W),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .LEN_W (LEN_W)
   ) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_seg      (req_seg),
      .req_off      (req_off),
      .req_acc      (req_acc),
      .tbl_base     (tbl_base),
      .tbl_len      (tbl_len),
      .mem_rd_req   (mem_rd_req),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_gnt   (mem_rd_gnt),
      .mem_rd_rvalid(mem_rd_rvalid),
      .mem_rd_data  (mem_rd_data),
      .seg_bad      (seg_bad),
      .cap_off      (cap_off),
      .cap_acc      (cap_acc),
      .ent_word0    (ent_word0),
      .ent_word1    (ent_word1),
      .res_valid    (res_valid)
   );

   seg_check #(
      .OFF_W   (OFF_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .LIM_W   (LIM_W),
      .PERM_LSB(PERM_LSB)
   ) u_check (
      .seg_bad  (seg_bad),
      .cap_off  (cap_off),
      .cap_acc  (cap_acc),
      .ent_word0(ent_word0),
      .ent_word1(ent_word1),
      .res_fault(res_fault),
      .res_paddr(res_paddr)
   );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_gnt,
   input logic              res_valid,
   input logic [1:0]        res_fault,
   input logic [ADDR_W-1:0] res_paddr
);

   // R5
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rd_gnt) |=> (mem_rd_req && $stable(mem_rd_addr)));

   // R10
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R10
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> req_ready);

   // R9
   fault_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault != 2'd0) |-> (res_paddr == '0));

   // R5
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> !(req_ready || res_valid));

endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W)) u_seg_xlate_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .mem_rd_req (mem_rd_req),
   .mem_rd_addr(mem_rd_addr),
   .mem_rd_gnt (mem_rd_gnt),
   .res_valid  (res_valid),
   .res_fault  (res_fault),
   .res_paddr  (res_paddr)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_seg = '0;
   logic [15:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_gnt = 1'b0;
   logic        mem_rd_rvalid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        res_valid;
   logic [1:0]  res_fault;
   logic [31:0] res_paddr;

   int n_chk = 0;
   int n_fail = 0;

   // bench view of the table
   logic [31:0] tbl_base_m = '0;
   int          tbl_len_m = 0;
   logic [31:0] ent_w0 [16];
   logic [31:0] ent_w1 [16];
   logic [15:0] cur_seg = '0;
   int          grants = 0;
   int          pend_cnt = 0;
   logic [31:0] pend_addr = '0;

   always #2 clk = ~clk;

   seg_xlate_unit dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_gnt(mem_rd_gnt), .mem_rd_rvalid(mem_rd_rvalid),
      .mem_rd_data(mem_rd_data),
      .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] d;
      int idx;
      d = a - tbl_base_m;
      idx = int'(d >> 3);
      if (d < 32'd128) return d[2] ? ent_w1[idx] : ent_w0[idx];
      return 32'hDEAD_BEEF;
   endfunction

   function automatic logic [1:0] exp_fault(input logic [15:0] s, input logic [15:0] o,
                                            input logic [1:0] a);
      logic [2:0] p;
      if (int'(s) >= tbl_len_m) return 2'd1;
      if (o >= ent_w1[s[3:0]][15:0]) return 2'd2;
      p = ent_w1[s[3:0]][18:16];
      if (a == 2'd3 || !p[a]) return 2'd3;
      return 2'd0;
   endfunction

   // memory responder: grant after a random wait, data 1..3 cycles later
   initial begin
      forever begin
         @(negedge clk);
         mem_rd_gnt = 1'b0;
         mem_rd_rvalid = 1'b0;
         if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
               mem_rd_rvalid = 1'b1;
               mem_rd_data = mem_word(pend_addr);
            end
         end else if (mem_rd_req && ($urandom % 3 != 0)) begin
            // R4: descriptor word addresses
            check(mem_rd_addr == tbl_base_m + 32'(cur_seg) * 8 + 32'(grants) * 4,
                  "R4 fetch address", mem_rd_addr,
                  tbl_base_m + 32'(cur_seg) * 8 + 32'(grants) * 4);
            mem_rd_gnt = 1'b1;
            pend_addr = mem_rd_addr;
            pend_cnt = 1 + int'($urandom % 3);
            grants++;
         end
      end
   end

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (!sel) tbl_base_m = d;
      else tbl_len_m = int'(d[16:0]);
   endtask

   task automatic translate(input logic [15:0] s, input logic [15:0] o,
                            input logic [1:0] a, input bit disturb);
      logic [1:0]  ef;
      logic [31:0] ep;
      int cyc;
      bit got;
      bit busy_bad;
      ef = exp_fault(s, o, a);
      ep = (ef == 2'd0) ? ent_w0[s[3:0]] + 32'(o) : 32'd0;
      @(negedge clk);
      cur_seg = s;
      grants = 0;
      req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0; cyc = 0; busy_bad = 1'b0;
      while (!got && cyc < 60) begin
         if (res_valid) got = 1'b1;
         else begin
            if (req_ready) busy_bad = 1'b1;
            if (disturb && cyc == 0) begin
               // R11: shrink the segment count while in flight
               cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'd0;
            end else cfg_we = 1'b0;
            @(negedge clk);
            cyc++;
         end
      end
      cfg_we = 1'b0;
      check(got, "R10 result pulse seen", 32'(got), 32'd1);
      check(!busy_bad, "R10 ready low while busy", 32'(busy_bad), 32'd0);
      check(res_fault == ef, (ef == 2'd1) ? "R3 fault" : (ef == 2'd2) ? "R6 fault" :
            (ef == 2'd3) ? "R7 fault" : "R9 fault", 32'(res_fault), 32'(ef));
      check(res_paddr == ep, "R9 physical address", res_paddr, ep);
      check(grants == ((ef == 2'd1) ? 0 : 2), "R4 read count", 32'(grants),
            (ef == 2'd1) ? 32'd0 : 32'd2);
      if (ef == 2'd1) check(cyc == 0, "R3 immediate result", 32'(cyc), 32'd0);
      @(negedge clk);
      check(!res_valid && req_ready, "R10 pulse ends and ready returns",
            {30'd0, res_valid, req_ready}, 32'd1);
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 16; i++) begin
         ent_w0[i] = $urandom;
         ent_w1[i] = {13'd0, 3'($urandom), 16'(16'h0040 + ($urandom % 16'h0200))};
      end
      ent_w1[3] = {13'd0, 3'b111, 16'd0};           // empty segment
      ent_w0[4] = 32'hFFFF_FFF0;                    // base close to wrap
      ent_w1[4] = {13'd0, 3'b001, 16'h0100};
      ent_w1[5] = {13'd0, 3'b000, 16'h0080};        // no permissions
      ent_w1[6] = {13'd0, 3'b010, 16'h0100};        // write only
      ent_w1[7] = {13'd0, 3'b100, 16'h0100};        // execute only
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready && !res_valid && !mem_rd_req, "R1 reset outputs",
            {29'd0, req_ready, res_valid, mem_rd_req}, 32'h4);
      rst_n = 1'b1;
      // R1: segment count is 0 after reset
      translate(16'd0, 16'd0, 2'd0, 1'b0);
      // R2: load the registers
      cfg_write(1'b0, 32'h1234_5670);
      cfg_write(1'b1, 32'd12);
      // R6: limit boundary
      translate(16'd4, 16'h00FF, 2'd0, 1'b0);
      translate(16'd4, 16'h0100, 2'd0, 1'b0);
      translate(16'd3, 16'd0, 2'd0, 1'b0);
      // R9: wrap of base plus offset
      translate(16'd4, 16'h0020, 2'd0, 1'b0);
      // R7: each access code against each permission
      for (int a = 0; a < 4; a++) begin
         translate(16'd6, 16'd1, 2'(a), 1'b0);
         translate(16'd7, 16'd1, 2'(a), 1'b0);
         translate(16'd5, 16'd1, 2'(a), 1'b0);
      end
      // R3: segment count boundary
      translate(16'd11, 16'd0, 2'd0, 1'b0);
      translate(16'd12, 16'd0, 2'd0, 1'b0);
      translate(16'hFFFF, 16'd0, 2'd0, 1'b0);
      // R8: priority between faults
      translate(16'd13, 16'hFFFF, 2'd3, 1'b0);
      translate(16'd5, 16'hFFFF, 2'd3, 1'b0);
      // R11: write during flight, then restore
      translate(16'd6, 16'd2, 2'd1, 1'b1);
      tbl_len_m = 0;
      cfg_write(1'b1, 32'd12);
      // R2: move the table and use a full count
      cfg_write(1'b0, 32'hFFFF_FFC0);
      cfg_write(1'b1, 32'd16);
      translate(16'd15, 16'd3, 2'd2, 1'b0);
      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [15:0] s;
         logic [15:0] o;
         s = 16'($urandom % 20);
         o = ($urandom % 2 == 0) ? 16'($urandom % 16'h0260) :
             16'(ent_w1[s[3:0]][15:0] - 16'(1 - int'($urandom % 2)));
         translate(s, o, 2'($urandom), 1'b0);
         if (n == 150) cfg_write(1'b1, 32'd9);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule